// File: doc/BRIEF.md
# Time Capture Counter Unit

This block measures when events happen. A free-running up-counter advances by one on every clock once software has started it. When a store event occurs, the counter's current value is copied into an image register. The image register is a snapshot of the time of the event. Two such units can timestamp the rising and falling edges of a pulse, and the difference between the two snapshots gives the pulse width.

A store event comes from one of three places: an external pin, the output of a programmable-logic cell, or a software strobe written over the register bus. A control field chooses the source. The two hardware inputs are synchronised and then edge-detected, and a control bit sets whether the active edge is rising or falling. While a processor reads a snapshot, it raises a freeze request. The block acknowledges the freeze and holds the image steady, and the counter keeps running. A store event that arrives during the freeze is not lost. It is held with its timestamp and written to the image once the freeze ends.

Top module: `tcap_unit`

## Requirements
- R1: After reset, the following are all zero: the counter, the image, the control register (read at address 0) and `frz_ack`. The counter does not advance until software sets the run bit.
- R2: A write to address 0 with bit 4 set clears the counter, the image and any pending capture at that clock edge. This clear takes priority over freeze. Bit 4 reads back as 0.
- R3: While control bit 0 (run) is 1, the counter rises by one on every clock. While run is 0, the counter holds its value.
- R4: The counter wraps from all ones to zero and keeps counting.
- R5: With the source field (control bits 2:1) equal to 2 (software), a write to address 1 with bit 0 set loads the image with the counter value of the write cycle, which is the value before that cycle's increment.
- R6: With the source field equal to 0 (pin) or 1 (logic cell), an active edge on that input is captured after a SYNC_STAGES-flop synchroniser. The image receives the count read in the cycle the input changed, plus SYNC_STAGES.
- R7: Control bit 3 selects the active edge: 0 for rising, 1 for falling. Steady levels and edges of the other polarity capture nothing.
- R8: Events from any source other than the selected one leave the image unchanged. Source value 3 selects no source.
- R9: `frz_ack` follows `frz_req` with a delay of one clock. While `frz_ack` is high, the image does not change unless R2 clears it.
- R10: The counter keeps advancing while the freeze is acknowledged.
- R11: A capture that arrives while `frz_ack` is high is held along with the count at the moment of the event. A later capture in the same freeze replaces it. The held value is written to the image in the first cycle in which `frz_ack` is low.
- R12: A read at address 2 returns the counter. A read at address 3 returns the image, and `img_val` always shows the image. Reads are combinational and are zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 strobe, 2 counter, 3 image) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| evt_pin | input | 1 | External pin event, asynchronous |
| evt_logic | input | 1 | Logic-cell event, asynchronous |
| frz_req | input | 1 | Freeze request from the processor |
| frz_ack | output | 1 | Freeze acknowledge |
| img_val | output | CNT_W | Captured image value |

## Verification
The bench builds the unit with CNT_W = 8 and SYNC_STAGES = 2. The narrow counter puts the all-ones-to-zero wrap within 256 cycles of a clear, so it can be observed at the exact cycle. With the two-stage synchroniser, the timestamp of a pin or logic-cell event is a fixed offset of two counts from the count read when the input changed. This lets every snapshot be checked for an exact value, including a pending capture that is replaced during a freeze.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int BUS_W  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        SRC_PIN   = 2'd0,
        SRC_LOGIC = 2'd1,
        SRC_SOFT  = 2'd2,
        SRC_NONE  = 2'd3
    } src_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_STROBE = 2'd1,
        REG_COUNT  = 2'd2,
        REG_IMAGE  = 2'd3
    } reg_addr_e;

    // Field layout: [4] clear, [3] falling, [2:1] src, [0] run
    typedef struct packed {
        logic     clear;
        logic     falling;
        src_sel_e src;
        logic     run;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [BUS_W-1:0] w);
        return ctrl_t'(w[4:0]);
    endfunction

    function automatic logic [BUS_W-1:0] widen(input logic [BUS_W-1:0] v);
        return v;
    endfunction

endpackage

// File: rtl/tcap_evt_sync.sv
module tcap_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    input  logic falling,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              settled;

    assign settled = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= settled;
        end
    end

    always_comb begin
        if (falling) edge_pulse = prev_q & ~settled;
        else         edge_pulse = settled & ~prev_q;
    end
endmodule

// File: rtl/tcap_counter.sv
module tcap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear) count <= '0;
        else if (run)     count <= count + 1'b1;
    end
endmodule

// File: rtl/tcap_snapshot.sv
module tcap_snapshot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             capture,
    input  logic [CNT_W-1:0] count,
    input  logic             frz_req,
    output logic             frz_ack,
    output logic [CNT_W-1:0] image
);
    logic             pend_q;
    logic [CNT_W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) frz_ack <= 1'b0;
        else     frz_ack <= frz_req;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            image    <= '0;
            pend_q   <= 1'b0;
            shadow_q <= '0;
        end else if (frz_ack) begin
            if (capture) begin
                pend_q   <= 1'b1;
                shadow_q <= count;
            end
        end else begin
            pend_q <= 1'b0;
            if (capture)     image <= count;
            else if (pend_q) image <= shadow_q;
        end
    end
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic                 evt_pin,
    input  logic                 evt_logic,
    input  logic                 frz_req,
    output logic                 frz_ack,
    output logic [CNT_W-1:0]     img_val
);
    localparam int N_HW_SRC = 2;

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_wr;
    logic             wr_ctrl;
    logic             wr_strobe;
    logic             clear_now;
    logic             soft_evt;
    logic             capture;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] image_q;
    logic [N_HW_SRC-1:0] hw_in;
    logic [N_HW_SRC-1:0] hw_edge;

    assign ctrl_wr   = unpack_ctrl(bus_wdata);
    assign wr_ctrl   = bus_we && (reg_addr_e'(bus_addr) == REG_CTRL);
    assign wr_strobe = bus_we && (reg_addr_e'(bus_addr) == REG_STROBE);
    assign clear_now = wr_ctrl && ctrl_wr.clear;
    assign soft_evt  = wr_strobe && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q       <= ctrl_wr;
            ctrl_q.clear <= 1'b0;
        end
    end

    assign hw_in = {evt_logic, evt_pin};

    for (genvar g = 0; g < N_HW_SRC; g++) begin : g_src
        tcap_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst       (rst),
            .async_in  (hw_in[g]),
            .falling   (ctrl_q.falling),
            .edge_pulse(hw_edge[g])
        );
    end

    always_comb begin
        unique case (ctrl_q.src)
            SRC_PIN:   capture = hw_edge[0];
            SRC_LOGIC: capture = hw_edge[1];
            SRC_SOFT:  capture = soft_evt;
            default:   capture = 1'b0;
        endcase
    end

    tcap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clear(clear_now),
        .run  (ctrl_q.run),
        .count(count_q)
    );

    tcap_snapshot #(.CNT_W(CNT_W)) u_snap (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear_now),
        .capture(capture),
        .count  (count_q),
        .frz_req(frz_req),
        .frz_ack(frz_ack),
        .image  (image_q)
    );

    assign img_val = image_q;

    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_e'(bus_addr))
            REG_CTRL:   bus_rdata = widen(BUS_W'(ctrl_q));
            REG_STROBE: bus_rdata = '0;
            REG_COUNT:  bus_rdata = widen(BUS_W'(count_q));
            REG_IMAGE:  bus_rdata = widen(BUS_W'(image_q));
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic                 frz_req,
    input logic                 frz_ack,
    input logic [CNT_W-1:0]     img_val,
    input logic [CNT_W-1:0]     cnt,
    input ctrl_t                ctrl_q
);
    logic clr_wr;
    logic sw_wr;
    assign clr_wr = bus_we && bus_addr == 2'd0 && bus_wdata[4];
    assign sw_wr  = bus_we && bus_addr == 2'd1 && bus_wdata[0];

    // R2
    a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> (cnt == '0 && img_val == '0));

    // R3, R10
    a_r10_count_advances: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && !clr_wr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R5
    a_r5_soft_capture: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && ctrl_q.src == SRC_SOFT && !frz_ack) |=> img_val == $past(cnt));

    // R9
    a_r9_ack_tracks_req: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> frz_ack == $past(frz_req));

    // R9
    a_r9_frozen_image: assert property (@(posedge clk) disable iff (rst)
        (frz_ack && !clr_wr) |=> $stable(img_val));
endmodule

bind tcap_unit tcap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .frz_req  (frz_req),
    .frz_ack  (frz_ack),
    .img_val  (img_val),
    .cnt      (count_q),
    .ctrl_q   (ctrl_q)
);

// File: tb/tcap_unit_test.sv
module tcap_unit_test;
    localparam int CW = 8;
    localparam int SS = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          evt_pin = 1'b0;
    logic          evt_logic = 1'b0;
    logic          frz_req = 1'b0;
    logic          frz_ack;
    logic [CW-1:0] img_val;

    int runs = 0;
    int fails = 0;

    always #4 clk = ~clk;

    tcap_unit #(.CNT_W(CW), .SYNC_STAGES(SS)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pin(evt_pin),
        .evt_logic(evt_logic), .frz_req(frz_req), .frz_ack(frz_ack),
        .img_val(img_val)
    );

    task automatic check(input string req, input int act, input int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // software strobe, returns count of the write cycle
    task automatic sw_store(output int c);
        @(negedge clk);
        rd(2'd2, c);
        bus_addr = 2'd1; bus_wdata = 16'd1; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // drive a hardware input, return count read in the change cycle
    task automatic drive_hw(input bit which, input logic val, output int c);
        @(negedge clk);
        rd(2'd2, c);
        if (which) evt_logic = val; else evt_pin = val;
        repeat (SS + 1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        repeat (3) @(negedge clk);
        rd(2'd2, v); check("R1 counter", v, 0);
        rd(2'd3, v); check("R1 image", v, 0);
        rd(2'd0, v); check("R1 ctrl", v, 0);
        check("R1 ack", int'(frz_ack), 0);
    endtask

    task automatic t_clear_wrap;
        int v;
        wr(2'd0, 16'h0011);              // clear + run, src pin
        rd(2'd2, v); check("R2 counter cleared", v, 0);
        rd(2'd3, v); check("R2 image cleared", v, 0);
        rd(2'd0, v); check("R2 clear bit reads 0", v, 1);
        repeat (255) @(posedge clk);
        @(negedge clk);
        rd(2'd2, v); check("R4 at all ones", v, 255);
        @(negedge clk);
        rd(2'd2, v); check("R4 wrapped", v, 0);
        @(negedge clk);
        rd(2'd2, v); check("R3 increments", v, 1);
    endtask

    task automatic t_hold;
        int a, b;
        wr(2'd0, 16'h0004);              // stopped, src soft
        rd(2'd2, a);
        repeat (5) @(negedge clk);
        rd(2'd2, b); check("R3 holds when stopped", b, a);
    endtask

    task automatic t_soft;
        int c, v;
        wr(2'd0, 16'h0005);              // run, src soft
        repeat (7) @(negedge clk);
        sw_store(c);
        check("R5 soft capture", int'(img_val), c);
        rd(2'd3, v); check("R12 image read", v, c);
    endtask

    task automatic t_pin;
        int c, v;
        wr(2'd0, 16'h0001);              // run, src pin, rising
        drive_hw(1'b0, 1'b1, c);
        check("R6 pin rising", int'(img_val), (c + SS) % 256);
        wr(2'd0, 16'h0009);              // falling
        drive_hw(1'b0, 1'b0, c);
        check("R7 pin falling", int'(img_val), (c + SS) % 256);
        v = int'(img_val);
        drive_hw(1'b0, 1'b1, c);
        repeat (3) @(negedge clk);
        check("R7 rising ignored when falling", int'(img_val), v);
    endtask

    task automatic t_logic;
        int c, v;
        wr(2'd0, 16'h0003);              // run, src logic, rising
        v = int'(img_val);
        drive_hw(1'b0, 1'b0, c);
        drive_hw(1'b0, 1'b1, c);
        check("R8 pin ignored", int'(img_val), v);
        sw_store(c);
        check("R8 soft ignored", int'(img_val), v);
        drive_hw(1'b1, 1'b1, c);
        check("R6 logic rising", int'(img_val), (c + SS) % 256);
        wr(2'd0, 16'h0007);              // src none
        v = int'(img_val);
        sw_store(c);
        drive_hw(1'b1, 1'b0, c);
        drive_hw(1'b1, 1'b1, c);
        check("R8 none selected", int'(img_val), v);
    endtask

    task automatic t_freeze;
        int c1, c2, a, b, v;
        wr(2'd0, 16'h0005);
        sw_store(c1);
        v = int'(img_val);
        @(negedge clk);
        frz_req = 1'b1;
        @(negedge clk);
        check("R9 ack rises", int'(frz_ack), 1);
        rd(2'd2, a);
        sw_store(c1);
        check("R9 image held", int'(img_val), v);
        repeat (3) @(negedge clk);
        sw_store(c2);
        check("R9 image still held", int'(img_val), v);
        rd(2'd2, b);
        check("R10 runs in freeze", (b - a + 256) % 256, (c2 - a + 256) % 256 + 1);
        @(negedge clk);
        frz_req = 1'b0;
        @(negedge clk);
        check("R9 ack falls", int'(frz_ack), 0);
        check("R11 not yet applied", int'(img_val), v);
        @(negedge clk);
        check("R11 pending applied", int'(img_val), c2);
    endtask

    task automatic t_clear_in_freeze;
        int v;
        @(negedge clk);
        frz_req = 1'b1;
        @(negedge clk);
        wr(2'd0, 16'h0015);
        rd(2'd3, v); check("R2 clear overrides freeze", v, 0);
        @(negedge clk);
        frz_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clear_wrap();
        t_hold();
        t_soft();
        t_pin();
        t_logic();
        t_freeze();
        t_clear_in_freeze();
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule